// File: doc/BRIEF.md
# Programmable Infrared Carrier Generator

This block makes the modulated carrier for an infrared remote-control output pin that can only pull low or let go. A 3-bit mode value picks one of seven carrier shapes, each a period and an active time counted in whole cycles of the raw oscillator clock `clk_i`. The instruction-rate divider has no effect on this timing. An eighth mode turns the carrier off, and the pin then follows the combined data-latch level. While the carrier shape is in its active phase, the pin is pulled low, which turns the LED on.

The processor writes the mode by pulsing `mode_we_i` for one cycle with the value on `mode_wdata_i`. The output latch that allows transmission drives `carrier_en_i`. `data_lvl_i` is the OR of the data output latches. `stop_i` is high while the core is in stop mode. The output `drive_low_o` is registered, so a change at the inputs shows up one clock edge later. The one exception is stop, which releases the pin in the same cycle it is raised. All the pins are plain level or strobe signals. No stream handshake is used.

Top module: `ircg_carrier_gen`

## Requirements
- R1: After the asynchronous active-low reset `rst_n_i`, `drive_low_o` is 0 (pin released) and the mode is 0.
- R2: Mode 0 repeats every 96 cycles and pulls low for 48 of them. Mode 1 repeats every 96 cycles and pulls low for 32. Each period starts with its active (`drive_low_o`=1) phase.
- R3: Mode 2 gives a 64-cycle period with 32 active cycles. Mode 3 gives a 65-cycle period with 22 active cycles.
- R4: Mode 4 gives an 87-cycle period with 29 active cycles.
- R5: Mode 6 gives a 91-cycle period with 31 active cycles. Mode 7 gives a 101-cycle period with 34 active cycles.
- R6: In mode 5 there is no carrier. While `carrier_en_i`=1, `drive_low_o` equals the `data_lvl_i` value sampled at the previous edge, so the pin is the inverse of the data level.
- R7: A mode write restarts the period count. The first active cycle of the new shape starts one edge after the write edge and lasts the full active time.
- R8: While `carrier_en_i`=0, `drive_low_o` is 0 from the next edge on and the period count stays at zero. Enabling again starts with a full active phase.
- R9: While `stop_i`=1, `drive_low_o` is 0 in that same cycle and the count stays at zero. After stop drops, the shape resumes with a full active phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw oscillator clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Core is in stop mode |
| mode_we_i | input | 1 | One-cycle mode write strobe |
| mode_wdata_i | input | 3 | Mode value to load |
| carrier_en_i | input | 1 | Carrier gate from the output latch |
| data_lvl_i | input | 1 | OR of the data output latches |
| drive_low_o | output | 1 | 1 pulls the pin low, 0 releases it |

## Verification
The bench measures every carrier mode over two full periods, sample by sample. This catches off-by-one period or active counts, and it catches the irregular 65-, 87-, 91- and 101-cycle wraps that a power-of-two counter would get wrong. It writes a new mode while the old shape is in its low phase. A design that kept the old count would start the new shape partway through and shorten its first active phase. Gate-off, stop and reset are each applied mid-period and then removed. A design that left the counter running through any of them would resume in the middle of a shape and not with a full active phase. A design that kept a stale mode after reset would show the wrong active time. Mode 5 is driven with changing data under gate and stop to check the one-edge follow and that the pin is released there too.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
  localparam int MODE_W = 3;
  localparam int TICK_W = 7;
  localparam logic [MODE_W-1:0] MODE_PASS = 3'd5;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [TICK_W-1:0] tick_t;

  typedef struct packed {
    tick_t period;
    tick_t active;
    logic  passthru;
  } shape_t;

  // period / active-time pairs in oscillator cycles
  function automatic shape_t shape_of(mode_t m);
    shape_t s;
    s.passthru = 1'b0;
    case (m)
      3'd0:    begin s.period = 7'd96;  s.active = 7'd48; end
      3'd1:    begin s.period = 7'd96;  s.active = 7'd32; end
      3'd2:    begin s.period = 7'd64;  s.active = 7'd32; end
      3'd3:    begin s.period = 7'd65;  s.active = 7'd22; end
      3'd4:    begin s.period = 7'd87;  s.active = 7'd29; end
      3'd6:    begin s.period = 7'd91;  s.active = 7'd31; end
      3'd7:    begin s.period = 7'd101; s.active = 7'd34; end
      default: begin s.period = 7'd1;   s.active = 7'd0;  s.passthru = 1'b1; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ircg_mode_reg.sv
module ircg_mode_reg #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  mode_o <= '0;
    else if (we_i) mode_o <= wdata_i;
  end
endmodule

// File: rtl/ircg_period_cnt.sv
module ircg_period_cnt #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         clear_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic wrap;
  assign wrap = (cnt_o >= period_i - ONE);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (wrap)    cnt_o <= '0;
    else              cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/ircg_drive_stage.sv
module ircg_drive_stage #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         stop_i,
  input  logic         gate_i,
  input  logic         passthru_i,
  input  logic         data_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] active_i,
  output logic         drive_low_o
);
  logic out_q;
  logic out_d;

  always_comb begin
    if (stop_i || !gate_i) out_d = 1'b0;
    else if (passthru_i)   out_d = data_i;
    else                   out_d = (cnt_i < active_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) out_q <= 1'b0;
    else          out_q <= out_d;
  end

  // stop releases the pin without waiting for an edge
  assign drive_low_o = out_q & ~stop_i;
endmodule

// File: rtl/ircg_carrier_gen.sv
module ircg_carrier_gen
  import ircg_pkg::*;
#(
  parameter int MW = ircg_pkg::MODE_W,
  parameter int TW = ircg_pkg::TICK_W
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          stop_i,
  input  logic          mode_we_i,
  input  logic [MW-1:0] mode_wdata_i,
  input  logic          carrier_en_i,
  input  logic          data_lvl_i,
  output logic          drive_low_o
);
  logic [MW-1:0] mode_q;
  logic [TW-1:0] cnt_q;
  shape_t        shape;
  logic          hold;

  ircg_mode_reg #(.W(MW)) u_mode (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .mode_o  (mode_q)
  );

  assign shape = shape_of(mode_q);
  assign hold  = stop_i | ~carrier_en_i | mode_we_i | shape.passthru;

  ircg_period_cnt #(.W(TW)) u_cnt (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .clear_i  (hold),
    .period_i (shape.period),
    .cnt_o    (cnt_q)
  );

  ircg_drive_stage #(.W(TW)) u_drv (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .stop_i      (stop_i),
    .gate_i      (carrier_en_i),
    .passthru_i  (shape.passthru),
    .data_i      (data_lvl_i),
    .cnt_i       (cnt_q),
    .active_i    (shape.active),
    .drive_low_o (drive_low_o)
  );
endmodule

// File: rtl/ircg_carrier_chk.sv
module ircg_carrier_chk
  import ircg_pkg::*;
(
  input logic        clk_i,
  input logic        rst_n_i,
  input logic        stop_i,
  input logic        mode_we_i,
  input logic        carrier_en_i,
  input logic        data_lvl_i,
  input logic        drive_low_o,
  input logic [2:0]  mode_q,
  input logic [6:0]  cnt_q,
  input logic [6:0]  period
);
  // R2 R3 R4 R5: the count never reaches the selected period
  a_r2_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q < period);

  // R7
  a_r7_write_restart: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mode_we_i |=> (cnt_q == 7'd0));

  // R8
  a_r8_gate_off: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !carrier_en_i |=> (!drive_low_o && cnt_q == 7'd0));

  // R9
  a_r9_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    stop_i |=> (cnt_q == 7'd0));

  a_r9_resume_active: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!stop_i && $past(stop_i) && carrier_en_i && mode_q != MODE_PASS)
      |=> (drive_low_o || stop_i));

  // R6
  a_r6_passthru: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_q == MODE_PASS && carrier_en_i && !stop_i)
      |=> (drive_low_o == ($past(data_lvl_i) && !stop_i)));
endmodule

bind ircg_carrier_gen ircg_carrier_chk u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .stop_i       (stop_i),
  .mode_we_i    (mode_we_i),
  .carrier_en_i (carrier_en_i),
  .data_lvl_i   (data_lvl_i),
  .drive_low_o  (drive_low_o),
  .mode_q       (mode_q),
  .cnt_q        (cnt_q),
  .period       (shape.period)
);

// File: tb/tb_ircg_carrier_gen.sv
`timescale 1ns/1ps
module tb_ircg_carrier_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop = 1'b0;
  logic       we = 1'b0;
  logic [2:0] wdata = 3'd0;
  logic       gate = 1'b0;
  logic       data = 1'b0;
  logic       drive;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ircg_carrier_gen dut (
    .clk_i        (clk),
    .rst_n_i      (rst_n),
    .stop_i       (stop),
    .mode_we_i    (we),
    .mode_wdata_i (wdata),
    .carrier_en_i (gate),
    .data_lvl_i   (data),
    .drive_low_o  (drive)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: drive_low_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_mode(logic [2:0] m);
    we = 1'b1; wdata = m;
    step();
    we = 1'b0;
  endtask

  // i-th sample after the first enabled edge: active while (i mod per) < act
  task automatic expect_shape(string tag, int per, int act, int n);
    for (int i = 0; i < n; i++) begin
      step();
      check(tag, drive, ((i % per) < act));
    end
  endtask

  task automatic run_shape(string tag, logic [2:0] m, int per, int act);
    gate = 1'b0;
    step();
    write_mode(m);
    gate = 1'b1;
    expect_shape(tag, per, act, 2 * per);
    gate = 1'b0;
    step();
  endtask

  task automatic t_reset_state();
    step();
    check("R1 in reset", drive, 1'b0);
    rst_n = 1'b1;
    step();
    check("R1 after reset", drive, 1'b0);
    gate = 1'b1;
    expect_shape("R1 default mode 0", 96, 48, 96);
    gate = 1'b0;
    step();
  endtask

  task automatic t_all_modes();
    run_shape("R2 mode 0", 3'd0, 96, 48);
    run_shape("R2 mode 1", 3'd1, 96, 32);
    run_shape("R3 mode 2", 3'd2, 64, 32);
    run_shape("R3 mode 3", 3'd3, 65, 22);
    run_shape("R4 mode 4", 3'd4, 87, 29);
    run_shape("R5 mode 6", 3'd6, 91, 31);
    run_shape("R5 mode 7", 3'd7, 101, 34);
  endtask

  task automatic t_passthru();
    logic [11:0] pat = 12'b1011_0011_1010;
    write_mode(3'd5);
    gate = 1'b1;
    for (int i = 0; i < 12; i++) begin
      data = pat[i];
      step();
      check("R6 follow data", drive, pat[i]);
    end
    data = 1'b1;
    gate = 1'b0;
    step();
    check("R8 gate off in mode 5", drive, 1'b0);
    gate = 1'b1;
    step();
    check("R6 data high", drive, 1'b1);
    stop = 1'b1;
    #1;
    check("R9 stop in mode 5", drive, 1'b0);
    step();
    stop = 1'b0;
    data = 1'b0;
    gate = 1'b0;
    step();
  endtask

  task automatic t_write_restart();
    write_mode(3'd7);
    gate = 1'b1;
    for (int i = 0; i < 50; i++) step();
    check("R7 old shape in low phase", drive, 1'b0);
    we = 1'b1; wdata = 3'd2;
    step();
    we = 1'b0;
    expect_shape("R7 restart mode 2", 64, 32, 64);
    gate = 1'b0;
    step();
  endtask

  task automatic t_gate();
    write_mode(3'd0);
    gate = 1'b1;
    for (int i = 0; i < 10; i++) step();
    check("R8 active before gate off", drive, 1'b1);
    gate = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R8 released while gated", drive, 1'b0);
    end
    gate = 1'b1;
    expect_shape("R8 full active on enable", 96, 48, 96);
  endtask

  task automatic t_stop();
    write_mode(3'd3);
    for (int i = 0; i < 5; i++) step();
    check("R9 active before stop", drive, 1'b1);
    stop = 1'b1;
    #1;
    check("R9 same-cycle release", drive, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step();
      check("R9 released in stop", drive, 1'b0);
    end
    stop = 1'b0;
    expect_shape("R9 resume full active", 65, 22, 65);
  endtask

  task automatic t_midrun_reset();
    write_mode(3'd6);
    for (int i = 0; i < 5; i++) step();
    rst_n = 1'b0;
    #1;
    check("R1 async release", drive, 1'b0);
    step();
    check("R1 held in reset", drive, 1'b0);
    rst_n = 1'b1;
    expect_shape("R1 mode back to 0", 96, 48, 96);
    gate = 1'b0;
    step();
  endtask

  initial begin
    t_reset_state();
    t_all_modes();
    t_passthru();
    t_write_restart();
    t_gate();
    t_stop();
    t_midrun_reset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule